// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Receiver with Address Filter

This block takes an asynchronous serial line and recovers 11-bit frames from it. A frame is a low start bit, eight data bits with the least significant bit first, a ninth bit and a stop bit. The line is examined on a tick enable that runs at sixteen times the bit rate. Each bit is decided by a vote of three samples taken near the middle of the bit. A start that does not hold for half a bit is dropped.

A received frame is handed over through a byte output, a ninth-bit output and a sticky done flag. The consumer clears the done flag with a one-cycle pulse. An address-filter mode input lets a node sleep through data traffic: while it is high, only frames whose ninth bit is 1 are accepted. A frame that arrives while the done flag is still set is discarded as a whole.

Top module: `ser9_rx`

## Requirements
- R1: While reset is asserted and right after it, `rx_done`, `rx_byte` and `rx_bit9` are 0.
- R2: A frame (start 0, data bits 0..7 in that order, ninth bit, stop bit) is presented as `rx_byte` with bit i equal to the i-th data bit, `rx_bit9` equal to the ninth bit, and `rx_done` set to 1.
- R3: Each bit takes the value held by at least two of the three samples taken on ticks 7, 8 and 9 of its sixteen-tick bit time. One corrupted sample does not change the received bit.
- R4: A falling edge whose first bit votes 1 causes no frame, leaves the outputs unchanged, and the next valid frame is received normally.
- R5: With `mp_mode` at 1, a frame whose ninth bit is 0 leaves all outputs unchanged, and a frame whose ninth bit is 1 is accepted.
- R6: While `rx_done` is 1, a new frame is discarded: `rx_byte`, `rx_bit9` and `rx_done` keep their values.
- R7: A one-cycle pulse on `rx_clr` sets `rx_done` to 0 on the next clock. `rx_byte` and `rx_bit9` keep their last accepted values.
- R8: The value of the stop bit has no effect on `rx_byte`, `rx_bit9` or `rx_done`.
- R9: The block searches for a new start edge one bit time after the ninth bit, so a frame that starts right at the end of the previous stop bit is received.
- R10: A line held low from reset onward produces no frame. Only a transition from 1 to 0 starts reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, asynchronous, idle high |
| mp_mode | input | 1 | Address filter: 1 accepts only frames with ninth bit 1 |
| rx_clr | input | 1 | Clears the done flag |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Last accepted ninth bit |
| rx_done | output | 1 | Sticky frame-received flag |

## Verification
The bench corrupts one sample in every bit of a frame, the start bit included. A design that used a single sample, or picked the wrong ticks, would deliver a wrong byte. It sends a low pulse shorter than half a bit, and a line held low from reset. A design that skipped the start vote, or came out of reset ready to see an edge, would report a frame of zeros. It sends frames while the done flag is set, zero ninth bits in filter mode, and low stop bits. A design that let any of these through would overwrite the byte or set the done flag. Two frames are sent back to back with no idle time between them; a design that went back to searching late would lose the second frame.

// File: rtl/ser9_rx_pkg.sv
package ser9_rx_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned FRAME_W  = DATA_W + 1;
    localparam int unsigned OSR      = 16;
    localparam int unsigned PH_W     = $clog2(OSR);
    localparam int unsigned VOTE_1ST = 7;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_BITS = 2'd1,
        ST_STOP = 2'd2
    } rx_st_e;

    typedef struct packed {
        rx_st_e              st;
        logic [PH_W-1:0]     phase;
        logic [FRAME_W-1:0]  shreg;
        logic                prev;
        logic [DATA_W-1:0]   data;
        logic                bit9;
        logic                done;
    } rx_regs_t;

endpackage

// File: rtl/ser9_rx_sync.sv
module ser9_rx_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ser9_rx_vote.sv
module ser9_rx_vote #(
    parameter int unsigned PH_W  = 4,
    parameter int unsigned FIRST = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic [PH_W-1:0] phase_now,
    input  logic            din,
    output logic            vote,
    output logic            vote_stb
);

    localparam logic [PH_W-1:0] PH_A = PH_W'(FIRST);
    localparam logic [PH_W-1:0] PH_B = PH_W'(FIRST + 1);
    localparam logic [PH_W-1:0] PH_C = PH_W'(FIRST + 2);

    logic [1:0] samp_d, samp_q;

    always_comb begin
        samp_d = samp_q;
        if (tick_en && phase_now == PH_A) samp_d[0] = din;
        if (tick_en && phase_now == PH_B) samp_d[1] = din;
        vote_stb = tick_en && (phase_now == PH_C);
        vote     = (samp_q[0] & samp_q[1]) | (samp_q[0] & din) | (samp_q[1] & din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= 2'b11;
        else        samp_q <= samp_d;
    end

endmodule

// File: rtl/ser9_rx.sv
module ser9_rx
    import ser9_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rxd,
    input  logic              mp_mode,
    input  logic              rx_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_done
);

    localparam logic [FRAME_W-1:0] SH_FILL = {FRAME_W{1'b1}};

    rx_regs_t          r_d, r_q;
    logic              rxd_s;
    logic [PH_W-1:0]   phase_now;
    logic              vote, vote_stb;
    logic [DATA_W-1:0] data_rev;
    logic              accept;
    logic              busy;

    ser9_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    ser9_rx_vote #(.PH_W(PH_W), .FIRST(VOTE_1ST)) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .phase_now(phase_now),
        .din      (rxd_s),
        .vote     (vote),
        .vote_stb (vote_stb)
    );

    // data bit 0 arrives first and ends up highest in the shift register
    always_comb begin
        for (int i = 0; i < int'(DATA_W); i++) begin
            data_rev[i] = r_q.shreg[DATA_W-1-i];
        end
    end

    assign phase_now = r_q.phase + 1'b1;
    assign accept    = !r_q.done && (!mp_mode || vote);
    assign busy      = (r_q.st != ST_HUNT);

    always_comb begin
        r_d      = r_q;
        r_d.done = r_q.done & ~rx_clr;
        if (tick_en) r_d.prev = rxd_s;

        unique case (r_q.st)
            ST_HUNT: begin
                if (tick_en && r_q.prev && !rxd_s) begin
                    r_d.st    = ST_BITS;
                    r_d.phase = '0;
                    r_d.shreg = SH_FILL;
                end
            end
            ST_BITS: begin
                if (tick_en) r_d.phase = phase_now;
                if (vote_stb) begin
                    if (r_q.shreg == SH_FILL && vote) begin
                        r_d.st = ST_HUNT;            // start bit not confirmed
                    end else if (!r_q.shreg[FRAME_W-1]) begin
                        r_d.shreg = {r_q.shreg[FRAME_W-2:0], vote};
                        r_d.st    = ST_STOP;
                        if (accept) begin
                            r_d.data = data_rev;
                            r_d.bit9 = vote;
                            r_d.done = 1'b1;
                        end
                    end else begin
                        r_d.shreg = {r_q.shreg[FRAME_W-2:0], vote};
                    end
                end
            end
            ST_STOP: begin
                if (tick_en) r_d.phase = phase_now;
                if (vote_stb) r_d.st = ST_HUNT;
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_HUNT;
            r_q.shreg <= SH_FILL;
            r_q.prev  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_byte = r_q.data;
    assign rx_bit9 = r_q.bit9;
    assign rx_done = r_q.done;

endmodule

// File: rtl/ser9_rx_chk.sv
module ser9_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       mp_mode,
    input logic       rx_clr,
    input logic [7:0] rx_byte,
    input logic       rx_bit9,
    input logic       rx_done,
    input logic       busy
);

    p_hold_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !rx_clr |=> rx_done);

    p_keep_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> $stable(rx_byte) && $stable(rx_bit9));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rx_clr |=> !rx_done);

    p_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mp_mode && $rose(rx_done) |-> rx_bit9);

    p_done_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(tick_en));

    p_busy_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(busy));

endmodule

bind ser9_rx ser9_rx_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .mp_mode(mp_mode),
    .rx_clr (rx_clr),
    .rx_byte(rx_byte),
    .rx_bit9(rx_bit9),
    .rx_done(rx_done),
    .busy   (busy)
);

// File: tb/test_ser9_rx.sv
module test_ser9_rx;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    // [11] accept expected, [10] mp_mode, [9] stop bit, [8] ninth bit, [7:0] byte
    localparam logic [11:0] VEC [0:7] = '{
        12'hAA5, 12'hB3C, 12'h800, 12'hBFF,
        12'h681, 12'hF5A, 12'h47E, 12'hD01
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en;
    logic       rxd = 1'b0;
    logic       mp_mode = 1'b0;
    logic       rx_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_done;

    logic [1:0] tick_cnt = '0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;
    logic [7:0] exp_byte;
    logic       exp_b9;

    always #10 clk = ~clk;

    always_ff @(posedge clk) tick_cnt <= tick_cnt + 1'b1;
    assign tick_en = (tick_cnt == 2'd0);

    ser9_rx i_ser9_rx (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rxd(rxd),
        .mp_mode(mp_mode), .rx_clr(rx_clr),
        .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_done(rx_done)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic v, bit glitch);
        rxd = v;
        if (glitch) begin
            wait_clks(32);
            rxd = ~v;
            wait_clks(TICK_DIV);
            rxd = v;
            wait_clks(BIT_CLKS - 32 - TICK_DIV);
        end else begin
            wait_clks(BIT_CLKS);
        end
    endtask

    // clr_in_stop: mid stop bit, check the frame and clear done
    task automatic send_frame(logic [7:0] b, logic b9, logic stp, bit glitch,
                              int idle_bits, bit clr_in_stop);
        send_bit(1'b0, glitch);
        for (int i = 0; i < 8; i++) send_bit(b[i], glitch);
        send_bit(b9, glitch);
        if (clr_in_stop) begin
            rxd = stp;
            wait_clks(32);
            check("R9 first frame byte", rx_byte, b);
            check("R9 first frame done", rx_done, 1);
            rx_clr = 1'b1;
            wait_clks(1);
            rx_clr = 1'b0;
            wait_clks(BIT_CLKS - 33);
        end else begin
            send_bit(stp, glitch);
        end
        rxd = 1'b1;
        wait_clks(idle_bits * BIT_CLKS);
    endtask

    task automatic clear_done();
        rx_clr = 1'b1;
        wait_clks(1);
        rx_clr = 1'b0;
        wait_clks(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, line held low throughout
        wait_clks(5);
        check("R1 done in reset", rx_done, 0);
        check("R1 byte in reset", rx_byte, 0);
        check("R1 bit9 in reset", rx_bit9, 0);
        rst_n = 1'b1;

        // R10: line low since reset gives no frame
        wait_clks(12 * BIT_CLKS);
        check("R10 no frame on low line", rx_done, 0);
        check("R1 byte after reset", rx_byte, 0);
        rxd = 1'b1;
        wait_clks(2 * BIT_CLKS);
        send_frame(8'h96, 1'b1, 1'b1, 0, 2, 0);
        check("R10 frame after line rises", rx_byte, 8'h96);
        check("R10 done after line rises", rx_done, 1);
        exp_byte = 8'h96;
        exp_b9   = 1'b1;

        // table: R2 format, R5 filter, R8 stop value ignored
        for (int i = 0; i < 8; i++) begin
            clear_done();
            mp_mode = VEC[i][10];
            send_frame(VEC[i][7:0], VEC[i][8], VEC[i][9], 0, 2, 0);
            if (VEC[i][11]) begin
                exp_byte = VEC[i][7:0];
                exp_b9   = VEC[i][8];
            end
            check(VEC[i][10] ? "R5 filter done" : "R2 done", rx_done, VEC[i][11]);
            check(VEC[i][9] ? "R2 byte" : "R8 byte stop low", rx_byte, exp_byte);
            check(VEC[i][10] ? "R5 filter bit9" : "R2 bit9", rx_bit9, exp_b9);
        end
        mp_mode = 1'b0;

        // R4: short low pulse rejected
        clear_done();
        rxd = 1'b0;
        wait_clks(2 * TICK_DIV);
        rxd = 1'b1;
        wait_clks(3 * BIT_CLKS);
        check("R4 false start done", rx_done, 0);
        check("R4 false start byte", rx_byte, exp_byte);
        send_frame(8'h4B, 1'b0, 1'b1, 0, 2, 0);
        check("R4 frame after false start", rx_byte, 8'h4B);
        check("R4 done after false start", rx_done, 1);

        // R3: one bad sample in every bit
        clear_done();
        send_frame(8'hC3, 1'b0, 1'b1, 1, 2, 0);
        check("R3 majority byte", rx_byte, 8'hC3);
        check("R3 majority bit9", rx_bit9, 0);
        check("R3 majority done", rx_done, 1);

        // R6: frame while done set is discarded
        send_frame(8'h11, 1'b1, 1'b1, 0, 2, 0);
        check("R6 byte kept", rx_byte, 8'hC3);
        check("R6 bit9 kept", rx_bit9, 0);
        check("R6 done kept", rx_done, 1);

        // R7: clear pulse
        clear_done();
        check("R7 done cleared", rx_done, 0);
        check("R7 byte kept", rx_byte, 8'hC3);

        // R9: back-to-back frames, no idle between
        send_frame(8'h2D, 1'b1, 1'b1, 0, 0, 1);
        send_frame(8'hD2, 1'b0, 1'b1, 0, 2, 0);
        check("R9 second frame byte", rx_byte, 8'hD2);
        check("R9 second frame bit9", rx_bit9, 0);
        check("R9 second frame done", rx_done, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule